// File: doc/BRIEF.md
# Byte-Lane Mask and Inversion Write/Read Datapath

This block sits between a memory controller's data path and the DQ pins of a DDR4-style memory interface. Each 8-bit lane of the data word has one extra pin that carries one of two meanings. In mask mode the pin blocks the write of its byte. In inversion mode the pin is an active-low flag that says the byte on DQ is the complement of the true data. A two-bit configuration input stands in for the memory's mode-register setting and chooses the meaning. Only one meaning is active at a time, and the pin can also be left unused.

On the write side the block takes a data word and one byte-enable bit per byte. It produces the DQ bytes and the per-lane pin values. In inversion mode a byte with more than four zero bits is sent complemented with its flag low, so no byte on the bus carries more than four zeros. On the read side it takes DQ bytes and pin values and returns true data. Each direction has exactly one register stage.

Top module: `lane_dbi_path`

## Requirements
- R1: The write outputs `dq_out`, `pin_out` and `wr_out_valid` change exactly one clock edge after `wr_valid`, `wr_data` and `wr_be` are sampled, and `wr_out_valid` repeats `wr_valid`.
- R2: With `mode_sel` = 2'b01 (mask), each lane's `pin_out` bit is the inverse of its `wr_be` bit (high blocks the byte) and the DQ byte is passed unchanged.
- R3: With `mode_sel` = 2'b10 (inversion), a write byte with five or more zero bits is sent complemented with its pin bit low. A byte with four or fewer zeros is sent unchanged with its pin bit high, so exactly four zeros is not inverted.
- R4: In inversion mode `wr_be` has no effect on `dq_out` or `pin_out`.
- R5: With `mode_sel` = 2'b00 or 2'b11 (pin unused), `pin_out` is all zero and the DQ bytes pass unchanged.
- R6: In inversion mode, a read lane whose `pin_in` bit is low returns the complement of its `dq_in` byte, and a lane whose bit is high returns the byte unchanged.
- R7: In mask mode and in the unused modes, `pin_in` is ignored on reads and `rd_data` equals `dq_in`.
- R8: `rd_data` and `rd_out_valid` change exactly one clock edge after `rd_valid`, `dq_in` and `pin_in` are sampled.
- R9: While `rst` is high, every output is zero.
- R10: In inversion mode, feeding the write outputs back into the read inputs returns the original data word, and no transmitted byte has more than four zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pin meaning: 00 unused, 01 mask, 10 inversion, 11 unused |
| wr_valid | input | 1 | Write word present |
| wr_data | input | DATA_W | True write data |
| wr_be | input | DATA_W/8 | Byte enables, bit i for bits [8i+7:8i] |
| dq_out | output | DATA_W | Bytes driven to the memory |
| pin_out | output | DATA_W/8 | Per-lane mask or active-low inversion flag |
| wr_out_valid | output | 1 | Write outputs hold a word |
| rd_valid | input | 1 | Read word present |
| dq_in | input | DATA_W | Bytes returned by the memory |
| pin_in | input | DATA_W/8 | Per-lane inversion flag from the memory |
| rd_data | output | DATA_W | Restored read data |
| rd_out_valid | output | 1 | Read outputs hold a word |

## Verification
The bench aims at the inversion threshold. A byte with exactly four zeros must stay true and a byte with five must flip. A design with an off-by-one compare would either flip 0x0F or leave 0x07 as it is. It also mixes enable patterns into inversion-mode writes, so a design that let the enables leak into the flag shows the wrong pin value. It drives low pin values in mask and unused modes, so a read path that inverted regardless of mode corrupts the data. A long round trip through the inversion path checks the zero-count limit on every byte that is sent.

// File: rtl/lane_dbi_pkg.sv
package lane_dbi_pkg;

    localparam int LANE_W    = 8;
    localparam int ZERO_MAX  = 4;
    localparam int ZCNT_W    = $clog2(LANE_W + 1);

    typedef enum logic [1:0] {
        PIN_UNUSED = 2'b00,
        PIN_MASK   = 2'b01,
        PIN_INVERT = 2'b10
    } pin_mode_e;

    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        lane_t dq;
        logic  pin;
    } lane_bus_t;

    function automatic pin_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return PIN_MASK;
            2'b10:   return PIN_INVERT;
            default: return PIN_UNUSED;
        endcase
    endfunction

    function automatic logic [ZCNT_W-1:0] zeros_in(input lane_t b);
        logic [ZCNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < LANE_W; i++) begin
            n = n + ZCNT_W'(~b[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/lane_dbi_wr.sv
module lane_dbi_wr
    import lane_dbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  logic      load,
    input  lane_t     data_in,
    input  logic      enable,
    output lane_bus_t lane_q
);

    lane_bus_t lane_d;
    logic      heavy;

    assign heavy = zeros_in(data_in) > ZCNT_W'(ZERO_MAX);

    always_comb begin
        lane_d.dq  = data_in;
        lane_d.pin = 1'b0;
        case (mode)
            PIN_MASK: begin
                lane_d.pin = ~enable;
            end
            PIN_INVERT: begin
                lane_d.dq  = heavy ? ~data_in : data_in;
                lane_d.pin = ~heavy;
            end
            default: begin
                lane_d.pin = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else if (load) begin
            lane_q <= lane_d;
        end
    end

endmodule

// File: rtl/lane_dbi_rd.sv
module lane_dbi_rd
    import lane_dbi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pin_mode_e mode,
    input  logic      load,
    input  lane_t     dq_in,
    input  logic      flag_n,
    output lane_t     data_q
);

    lane_t data_d;

    always_comb begin
        if (mode == PIN_INVERT && !flag_n) begin
            data_d = ~dq_in;
        end else begin
            data_d = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (load) begin
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/lane_dbi_path.sv
module lane_dbi_path
    import lane_dbi_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               mode_sel,
    input  logic                     wr_valid,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [DATA_W/8-1:0]      wr_be,
    output logic [DATA_W-1:0]        dq_out,
    output logic [DATA_W/8-1:0]      pin_out,
    output logic                     wr_out_valid,
    input  logic                     rd_valid,
    input  logic [DATA_W-1:0]        dq_in,
    input  logic [DATA_W/8-1:0]      pin_in,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_out_valid
);

    localparam int LANES = DATA_W / LANE_W;

    initial begin
        if (DATA_W % LANE_W != 0 || DATA_W < LANE_W) begin
            $error("lane_dbi_path: DATA_W must be a nonzero multiple of 8");
        end
    end

    pin_mode_e mode;
    assign mode = decode_mode(mode_sel);

    lane_bus_t wr_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_dbi_wr u_wr (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .load    (wr_valid),
            .data_in (wr_data[g*LANE_W +: LANE_W]),
            .enable  (wr_be[g]),
            .lane_q  (wr_lane[g])
        );

        assign dq_out[g*LANE_W +: LANE_W] = wr_lane[g].dq;
        assign pin_out[g]                 = wr_lane[g].pin;

        lane_dbi_rd u_rd (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .load   (rd_valid),
            .dq_in  (dq_in[g*LANE_W +: LANE_W]),
            .flag_n (pin_in[g]),
            .data_q (rd_data[g*LANE_W +: LANE_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_out_valid <= 1'b0;
            rd_out_valid <= 1'b0;
        end else begin
            wr_out_valid <= wr_valid;
            rd_out_valid <= rd_valid;
        end
    end

endmodule

// File: rtl/lane_dbi_path_chk.sv
module lane_dbi_path_chk
    import lane_dbi_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode_sel,
    input logic                wr_valid,
    input logic [DATA_W-1:0]   wr_data,
    input logic [DATA_W/8-1:0] wr_be,
    input logic [DATA_W-1:0]   dq_out,
    input logic [DATA_W/8-1:0] pin_out,
    input logic                wr_out_valid,
    input logic                rd_valid,
    input logic [DATA_W-1:0]   dq_in,
    input logic [DATA_W-1:0]   rd_data,
    input logic                rd_out_valid
);

    localparam int LANES = DATA_W / LANE_W;

    function automatic logic any_heavy(input logic [DATA_W-1:0] w);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (zeros_in(w[i*LANE_W +: LANE_W]) > ZCNT_W'(ZERO_MAX)) bad = 1'b1;
        end
        return bad;
    endfunction

    // R1
    wr_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (wr_out_valid == $past(wr_valid)));

    // R8
    rd_valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rd_out_valid == $past(rd_valid)));

    // R2
    mask_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_valid) && $past(mode_sel) == 2'b01)
        |-> (pin_out == ~$past(wr_be) && dq_out == $past(wr_data)));

    // R5
    unused_pin_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_valid) && ($past(mode_sel) == 2'b00 || $past(mode_sel) == 2'b11))
        |-> (pin_out == '0 && dq_out == $past(wr_data)));

    // R3 R10
    zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_valid) && $past(mode_sel) == 2'b10)
        |-> !any_heavy(dq_out));

    // R7
    rd_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_valid) && $past(mode_sel) != 2'b10)
        |-> (rd_data == $past(dq_in)));

endmodule

bind lane_dbi_path lane_dbi_path_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mode_sel     (mode_sel),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .wr_be        (wr_be),
    .dq_out       (dq_out),
    .pin_out      (pin_out),
    .wr_out_valid (wr_out_valid),
    .rd_valid     (rd_valid),
    .dq_in        (dq_in),
    .rd_data      (rd_data),
    .rd_out_valid (rd_out_valid)
);

// File: tb/lane_dbi_path_test.sv
module lane_dbi_path_test;

    localparam int W  = 16;
    localparam int NB = W / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = '0;
    logic          wr_valid = 1'b0;
    logic [W-1:0]  wr_data  = '0;
    logic [NB-1:0] wr_be    = '0;
    logic [W-1:0]  dq_out;
    logic [NB-1:0] pin_out;
    logic          wr_out_valid;
    logic          rd_valid = 1'b0;
    logic [W-1:0]  dq_in    = '0;
    logic [NB-1:0] pin_in   = '0;
    logic [W-1:0]  rd_data;
    logic          rd_out_valid;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    lane_dbi_path #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be),
        .dq_out(dq_out), .pin_out(pin_out), .wr_out_valid(wr_out_valid),
        .rd_valid(rd_valid), .dq_in(dq_in), .pin_in(pin_in),
        .rd_data(rd_data), .rd_out_valid(rd_out_valid)
    );

    // {mode[37:36], data[35:20], be[19:18], exp_dq[17:2], exp_pin[1:0]}
    localparam logic [37:0] WR_VEC [10] = '{
        {2'b01, 16'hA55A, 2'b10, 16'hA55A, 2'b01},
        {2'b01, 16'h1234, 2'b00, 16'h1234, 2'b11},
        {2'b10, 16'h0000, 2'b00, 16'hFFFF, 2'b00},
        {2'b10, 16'hFFFF, 2'b00, 16'hFFFF, 2'b11},
        {2'b10, 16'h0F01, 2'b11, 16'h0FFE, 2'b10},
        {2'b10, 16'h1F07, 2'b11, 16'h1FF8, 2'b10},
        {2'b00, 16'h00F0, 2'b01, 16'h00F0, 2'b00},
        {2'b11, 16'h8001, 2'b11, 16'h8001, 2'b00},
        {2'b10, 16'h7E10, 2'b01, 16'h7EEF, 2'b10},
        {2'b10, 16'hE003, 2'b10, 16'h1FFC, 2'b00}
    };

    // {mode[35:34], dq[33:18], pin[17:16], exp_data[15:0]}
    localparam logic [35:0] RD_VEC [6] = '{
        {2'b10, 16'hFFFF, 2'b00, 16'h0000},
        {2'b10, 16'h0FFE, 2'b10, 16'h0F01},
        {2'b01, 16'h1234, 2'b00, 16'h1234},
        {2'b00, 16'hA5A5, 2'b01, 16'hA5A5},
        {2'b11, 16'h5A5A, 2'b10, 16'h5A5A},
        {2'b10, 16'h1FFC, 2'b00, 16'hE003}
    };

    function automatic int tb_zeros(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (b[i] == 1'b0) n++;
        return n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input logic [W-1:0] d, input logic [NB-1:0] be);
        @(negedge clk);
        mode_sel = m; wr_valid = 1'b1; wr_data = d; wr_be = be;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] m, input logic [W-1:0] d, input logic [NB-1:0] p);
        @(negedge clk);
        mode_sel = m; rd_valid = 1'b1; dq_in = d; pin_in = p;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [W-1:0] lfsr;
        logic [W-1:0] sent;
        logic [NB-1:0] sent_pin;

        // R9: reset state, with live inputs held during reset
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 16'hFFFF; rd_valid = 1'b1; dq_in = 16'hFFFF; mode_sel = 2'b10;
        @(negedge clk);
        check("R9 dq_out", 32'(dq_out), 32'h0);
        check("R9 pin_out", 32'(pin_out), 32'h0);
        check("R9 valids", {30'h0, wr_out_valid, rd_out_valid}, 32'h0);
        check("R9 rd_data", 32'(rd_data), 32'h0);
        wr_valid = 1'b0; rd_valid = 1'b0; dq_in = '0; wr_data = '0;
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R4 R5: write vector table
        foreach (WR_VEC[i]) begin
            do_write(WR_VEC[i][37:36], WR_VEC[i][35:20], WR_VEC[i][19:18]);
            // sampled one negedge after the capturing edge
            check($sformatf("R2/R3/R4/R5 wr dq row %0d", i), 32'(dq_out), 32'(WR_VEC[i][17:2]));
            check($sformatf("R2/R3/R4/R5 wr pin row %0d", i), 32'(pin_out), 32'(WR_VEC[i][1:0]));
            check($sformatf("R1 wr valid row %0d", i), 32'(wr_out_valid), 32'h1);
        end
        @(negedge clk);
        check("R1 wr valid drops", 32'(wr_out_valid), 32'h0);

        // R6 R7: read vector table
        foreach (RD_VEC[i]) begin
            do_read(RD_VEC[i][35:34], RD_VEC[i][33:18], RD_VEC[i][17:16]);
            check($sformatf("R6/R7 rd data row %0d", i), 32'(rd_data), 32'(RD_VEC[i][15:0]));
            check($sformatf("R8 rd valid row %0d", i), 32'(rd_out_valid), 32'h1);
        end
        @(negedge clk);
        check("R8 rd valid drops", 32'(rd_out_valid), 32'h0);

        // R1: outputs hold when no new write arrives
        do_write(2'b01, 16'hC3C3, 2'b01);
        @(negedge clk);
        check("R1 dq holds", 32'(dq_out), 32'hC3C3);

        // R10: round trip through inversion path
        lfsr = 16'hACE1;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_write(2'b10, lfsr, NB'(k));
            sent = dq_out;
            sent_pin = pin_out;
            for (int b = 0; b < NB; b++) begin
                check("R10 zero limit", 32'(tb_zeros(sent[b*8 +: 8]) <= 4), 32'h1);
            end
            do_read(2'b10, sent, sent_pin);
            check("R10 round trip", 32'(rd_data), 32'(lfsr));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule